// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block is the receive side of a serial port that works in synchronous slave mode. An external master supplies the serial clock. The block takes one data bit from a single data line on each falling edge of that clock, least significant bit first. It collects a character of 8 or 9 bits and moves the character into a two-entry receive FIFO. Each FIFO entry holds the 9th bit next to its byte. Software reads the FIFO one byte at a time through a small register port. A receive-complete flag stays high while the FIFO holds data. When the receive interrupt enable is high, the flag also drives an interrupt request. If the system is asleep, the same condition drives a wake request.

The receiver needs no per-character request. It stays armed for as long as all of these hold: the port enable bit is set, the continuous-receive bit is set, the synchronous mode bit is set, the clock source bit is clear and address detection is off. The single-receive bit can be written and read back but does nothing. A character that completes while the FIFO is full is an overrun. The overrun character is dropped, the overrun bit latches, and no further character enters the FIFO until software clears the continuous-receive bit. Sleep does not stop reception.

The shift sequencer has three states:
- RX_OFF: the receiver is disarmed. It moves to RX_SHIFT once the receiver is armed.
- RX_SHIFT: the sequencer captures a bit on each falling edge. After the last bit of the frame it moves to RX_DONE.
- RX_DONE: the sequencer presents the character for one cycle, then returns to RX_SHIFT.

From any state, disarming the receiver returns the sequencer to RX_OFF.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, the receive control register (address 0) reads 0x00, the transmit control register (address 1) reads 0x02, and rx_flag, irq_o and wake_o are 0.
- R2: When armed in 8-bit mode, the block samples 8 bits on falling edges of sclk_in, least significant bit first. The data register (address 2) then returns that byte and rx_flag goes high.
- R3: In 9-bit mode (receive control bit 6 set), the 9th bit received is visible in receive control bit 0 while its character is at the FIFO head. The data register returns the lower 8 bits.
- R4: The FIFO holds two characters and returns them in arrival order. Each read of the data register removes the head character. rx_flag is high exactly while the FIFO is not empty.
- R5: irq_o is high while rx_flag and rx_int_en are both high. wake_o is additionally gated by sleep_i. Reception continues while sleep_i is high.
- R6: A character that completes while the FIFO holds two characters sets the overrun bit (receive control bit 1) and is discarded. While the overrun bit is set, no later character enters the FIFO.
- R7: The overrun bit ignores writes. It stays set while continuous receive (bit 4) stays set. It clears when bit 4 is cleared, after which reception can resume.
- R8: Reception happens only while all of these hold: port enable (receive control bit 7), continuous receive (bit 4) and synchronous mode (transmit control bit 4) are set, and clock source (transmit control bit 7) and address detect (receive control bit 3) are clear.
- R9: The single-receive bit (receive control bit 5) reads back as written and has no effect. With it set and bit 4 clear, nothing is received. With bit 4 set, every character is received.
- R10: In the transmit control register, bit 3 always reads 0 and bit 1 always reads 1. The other bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the external master |
| sdata_in | input | 1 | Serial data line |
| reg_addr | input | 2 | Register select: 0 receive control, 1 transmit control, 2 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; when the data register is selected, it removes the FIFO head |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| rx_int_en | input | 1 | Receive interrupt enable |
| sleep_i | input | 1 | System is in low-power sleep |
| rx_flag | output | 1 | Receive complete: the FIFO holds data |
| irq_o | output | 1 | Receive interrupt request |
| wake_o | output | 1 | Wake request during sleep |

## Verification
The result of a falling sclk_in edge lands on the fourth rising clk edge after it. Two edges pass through the synchronizer, the third edge captures the bit and enters RX_DONE, and the fourth writes the FIFO. Each scenario task therefore holds sclk_in for four clocks in each phase and waits eight clocks after the final falling edge before sampling. Register values are sampled one nanosecond after the address settles on a falling clk edge, because reg_rdata is combinational. A FIFO removal takes effect on the next rising edge, so the flag is checked on the falling edge after the read pulse.

// File: rtl/sslv_rx_pkg.sv
package sslv_rx_pkg;

    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_RXCTL = 2'd0;
    localparam logic [1:0] ADDR_TXCTL = 2'd1;
    localparam logic [1:0] ADDR_RXDAT = 2'd2;

    localparam int RXB_PORT_EN = 7;
    localparam int RXB_NINE_EN = 6;
    localparam int RXB_SINGLE  = 5;
    localparam int RXB_CONT    = 4;
    localparam int RXB_ADDR_EN = 3;
    localparam int RXB_OVR     = 1;
    localparam int RXB_BIT9    = 0;

    localparam int TXB_CLK_SRC = 7;
    localparam int TXB_SYNC    = 4;

    localparam logic [REG_W-1:0] RX_RW_MASK = 8'hF8;
    localparam logic [REG_W-1:0] TX_RW_MASK = 8'hF5;
    localparam logic [REG_W-1:0] TX_RO_ONES = 8'h02;

    typedef enum logic [1:0] {
        RX_OFF   = 2'd0,
        RX_SHIFT = 2'd1,
        RX_DONE  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/sslv_rx_sync.sv
module sslv_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic sdat_raw,
    output logic sclk_fall,
    output logic sdat_s
);

    logic [STAGES-1:0] clk_chain;
    logic [STAGES-1:0] dat_chain;
    logic              clk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        clk_chain[0] <= 1'b0;
                        dat_chain[0] <= 1'b0;
                    end else begin
                        clk_chain[0] <= sclk_raw;
                        dat_chain[0] <= sdat_raw;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        clk_chain[g] <= 1'b0;
                        dat_chain[g] <= 1'b0;
                    end else begin
                        clk_chain[g] <= clk_chain[g-1];
                        dat_chain[g] <= dat_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_chain[STAGES-1];
    end

    assign sclk_fall = clk_prev & ~clk_chain[STAGES-1];
    assign sdat_s    = dat_chain[STAGES-1];

endmodule

// File: rtl/sslv_rx_shift.sv
module sslv_rx_shift
    import sslv_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            armed,
    input  logic            nine_en,
    input  logic            bit_fall,
    input  logic            bit_val,
    output logic            char_vld,
    output logic [DATA_W:0] char_data
);

    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DATA_W:0]  sr_q;
    logic [CNT_W-1:0] last_idx;
    logic             last_bit;

    assign last_idx = nine_en ? CNT_W'(FRAME_W - 1) : CNT_W'(DATA_W - 1);
    assign last_bit = bit_fall && (cnt_q == last_idx);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_OFF:   if (armed) state_d = RX_SHIFT;
            RX_SHIFT: if (!armed) state_d = RX_OFF;
                      else if (last_bit) state_d = RX_DONE;
            RX_DONE:  state_d = armed ? RX_SHIFT : RX_OFF;
            default:  state_d = RX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (state_q != RX_SHIFT) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (bit_fall) begin
            sr_q[cnt_q] <= bit_val;
            cnt_q       <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        char_vld  = (state_q == RX_DONE);
        char_data = nine_en ? sr_q : {1'b0, sr_q[DATA_W-1:0]};
    end

    p_off_when_disarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> state_q == RX_OFF);

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME_W));

endmodule

// File: rtl/sslv_rx_fifo.sv
module sslv_rx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= push_data;
    end

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign head  = empty ? '0 : mem_q[rd_ptr_q];

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
    import sslv_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             sdata_in,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_rd,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             rx_int_en,
    input  logic             sleep_i,
    output logic             rx_flag,
    output logic             irq_o,
    output logic             wake_o
);

    localparam int ENTRY_W = DATA_W + 1;

    logic [REG_W-1:0]   rxc_q, txc_q;
    logic               ovr_q;
    logic               port_en, nine_en, cont_en, addr_en, clk_src, sync_en;
    logic               armed;
    logic               sclk_fall, sdat_s;
    logic               char_vld;
    logic [DATA_W:0]    char_data;
    logic               fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [ENTRY_W-1:0] fifo_head;
    logic [REG_W-1:0]   rx_view, tx_view, dat_view;

    assign port_en = rxc_q[RXB_PORT_EN];
    assign nine_en = rxc_q[RXB_NINE_EN];
    assign cont_en = rxc_q[RXB_CONT];
    assign addr_en = rxc_q[RXB_ADDR_EN];
    assign clk_src = txc_q[TXB_CLK_SRC];
    assign sync_en = txc_q[TXB_SYNC];

    assign armed = port_en && cont_en && sync_en && !clk_src && !addr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxc_q <= '0;
            txc_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_RXCTL) rxc_q <= reg_wdata & RX_RW_MASK;
            if (reg_addr == ADDR_TXCTL) txc_q <= reg_wdata & TX_RW_MASK;
        end
    end

    sslv_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_raw  (sclk_in),
        .sdat_raw  (sdata_in),
        .sclk_fall (sclk_fall),
        .sdat_s    (sdat_s)
    );

    sslv_rx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .nine_en   (nine_en),
        .bit_fall  (sclk_fall),
        .bit_val   (sdat_s),
        .char_vld  (char_vld),
        .char_data (char_data)
    );

    assign fifo_push = char_vld && !fifo_full && !ovr_q;
    assign fifo_pop  = reg_rd && (reg_addr == ADDR_RXDAT) && !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ovr_q <= 1'b0;
        else if (!cont_en)                ovr_q <= 1'b0;
        else if (char_vld && fifo_full)   ovr_q <= 1'b1;
    end

    sslv_rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (char_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    always_comb begin
        rx_view           = rxc_q & RX_RW_MASK;
        rx_view[RXB_OVR]  = ovr_q;
        rx_view[RXB_BIT9] = fifo_head[DATA_W];
        tx_view           = (txc_q & TX_RW_MASK) | TX_RO_ONES;
        dat_view          = REG_W'(fifo_head[DATA_W-1:0]);
        case (reg_addr)
            ADDR_RXCTL: reg_rdata = rx_view;
            ADDR_TXCTL: reg_rdata = tx_view;
            ADDR_RXDAT: reg_rdata = dat_view;
            default:    reg_rdata = '0;
        endcase
    end

    assign rx_flag = !fifo_empty;
    assign irq_o   = rx_flag && rx_int_en;
    assign wake_o  = irq_o && sleep_i;

    p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q && cont_en && !(reg_wr && reg_addr == ADDR_RXCTL) |=> ovr_q);

    p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_en |=> !ovr_q);

    p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> !fifo_push);

    p_push_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(armed));

endmodule

// File: tb/sync_slave_rx_tb_top.sv
module sync_slave_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sdata_in = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       rx_int_en = 1'b0;
    logic       sleep_i = 1'b0;
    logic       rx_flag, irq_o, wake_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sync_slave_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .sdata_in  (sdata_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .rx_int_en (rx_int_en),
        .sleep_i   (sleep_i),
        .rx_flag   (rx_flag),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk);
        reg_addr = 2'd2;
        #1 d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input logic [8:0] v, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sdata_in = v[i];
            sclk_in  = 1'b1;
            repeat (4) @(negedge clk);
            sclk_in  = 1'b0;
            repeat (4) @(negedge clk);
        end
        sclk_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(2'd0, d); chk("R1 rx ctl reset", d, 8'h00);
        peek(2'd1, d); chk("R1 tx ctl reset", d, 8'h02);
        chk("R1 flag/irq/wake reset", {rx_flag, irq_o, wake_o}, 3'b000);
    endtask

    task automatic t_txreg();
        logic [7:0] d;
        wr(2'd1, 8'hFF); peek(2'd1, d); chk("R10 tx readback ff", d, 8'hF7);
        wr(2'd1, 8'h00); peek(2'd1, d); chk("R10 tx readback 00", d, 8'h02);
    endtask

    task automatic t_arming();
        wr(2'd1, 8'h00); wr(2'd0, 8'h90); send(9'h0AA, 8);
        chk("R8 no rx without sync", rx_flag, 1'b0);
        wr(2'd1, 8'h90); send(9'h0AA, 8);
        chk("R8 no rx with clock source", rx_flag, 1'b0);
        wr(2'd1, 8'h10); wr(2'd0, 8'h98); send(9'h0AA, 8);
        chk("R8 no rx with address detect", rx_flag, 1'b0);
        wr(2'd0, 8'h10); send(9'h0AA, 8);
        chk("R8 no rx without port enable", rx_flag, 1'b0);
    endtask

    task automatic t_8bit();
        logic [7:0] d;
        wr(2'd1, 8'h10); wr(2'd0, 8'h90);
        send(9'h0A5, 8);
        chk("R2 flag after char", rx_flag, 1'b1);
        pop(d); chk("R2 data a5", d, 8'hA5);
        @(negedge clk); chk("R4 flag clear after read", rx_flag, 1'b0);
        send(9'h03C, 8);
        pop(d); chk("R2 data 3c", d, 8'h3C);
    endtask

    task automatic t_fifo();
        logic [7:0] d;
        send(9'h011, 8); send(9'h022, 8);
        pop(d); chk("R4 first entry", d, 8'h11);
        @(negedge clk); chk("R4 flag held with one left", rx_flag, 1'b1);
        pop(d); chk("R4 second entry", d, 8'h22);
        @(negedge clk); chk("R4 flag clear when empty", rx_flag, 1'b0);
    endtask

    task automatic t_9bit();
        logic [7:0] d;
        wr(2'd0, 8'hD0);
        send(9'h15A, 9);
        peek(2'd0, d); chk("R3 ninth bit set", d, 8'hD1);
        pop(d); chk("R3 low byte 5a", d, 8'h5A);
        send(9'h0C3, 9);
        peek(2'd0, d); chk("R3 ninth bit clear", d, 8'hD0);
        pop(d); chk("R3 low byte c3", d, 8'hC3);
        wr(2'd0, 8'h90);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        rx_int_en = 1'b1; sleep_i = 1'b1;
        send(9'h077, 8);
        chk("R5 irq and wake in sleep", {irq_o, wake_o}, 2'b11);
        sleep_i = 1'b0;
        @(negedge clk); chk("R5 irq without wake awake", {irq_o, wake_o}, 2'b10);
        pop(d); chk("R5 char received during sleep", d, 8'h77);
        @(negedge clk); chk("R5 irq clear", irq_o, 1'b0);
        rx_int_en = 1'b0;
        send(9'h078, 8);
        chk("R5 no irq when disabled", irq_o, 1'b0);
        pop(d);
    endtask

    task automatic t_single();
        logic [7:0] d;
        wr(2'd0, 8'hA0);
        peek(2'd0, d); chk("R9 single bit readback", d, 8'hA0);
        send(9'h0E1, 8);
        chk("R9 single bit alone receives nothing", rx_flag, 1'b0);
        wr(2'd0, 8'hB0);
        send(9'h0E2, 8); send(9'h0E3, 8);
        pop(d); chk("R9 continuous first", d, 8'hE2);
        pop(d); chk("R9 continuous second", d, 8'hE3);
        wr(2'd0, 8'h90);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        send(9'h001, 8); send(9'h002, 8); send(9'h003, 8);
        peek(2'd0, d); chk("R6 overrun bit set", d, 8'h92);
        pop(d); chk("R6 first kept", d, 8'h01);
        pop(d); chk("R6 second kept", d, 8'h02);
        @(negedge clk); chk("R6 third discarded", rx_flag, 1'b0);
        send(9'h004, 8);
        chk("R6 transfers blocked", rx_flag, 1'b0);
        wr(2'd0, 8'h90);
        peek(2'd0, d); chk("R7 overrun survives write", d, 8'h92);
        wr(2'd0, 8'h80);
        peek(2'd0, d); chk("R7 overrun cleared", d, 8'h80);
        wr(2'd0, 8'h90);
        send(9'h055, 8);
        pop(d); chk("R7 reception resumes", d, 8'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_txreg();
        t_arming();
        t_8bit();
        t_fifo();
        t_9bit();
        t_irq();
        t_single();
        t_overrun();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule